// File: doc/BRIEF.md
# Fixed-Frequency Boost Gate Pulse Generator

This block produces the switch drive for a boost power stage, one fixed-rate cycle at a time. A free-running counter divides the system clock down to the switching rate. Every cycle opens with a forced off interval. During that interval the external ramp is held discharged and the gate stays low. Once the interval ends, the ramp is released. The gate turns on at the clock after the external comparator reports that the ramp has reached the averaged-current level. The gate then stays on until the cycle ends.

A separate peak-current flag passes through a filter that rejects short spikes. When the filtered flag asserts, the gate drops in the same clock and stays off for the rest of the cycle. A disable input from the protection supervisor holds the gate low and the ramp discharged. The off-interval length is derived at elaboration as the larger of two values: the minimum off time, and the off time needed to keep the duty cycle under its ceiling.

Top module: `pfc_pwm_gate`

## Requirements
- R1: `cyc_start_o` is high for exactly one clock in every `PER_CYC` clocks (400 at defaults). It is high while the cycle counter is at zero, including during reset.
- R2: For the first `OFF_CYC` clocks of every cycle (20 at defaults), `gate_o` and `ramp_rel_o` are both low. `OFF_CYC` is the larger of the minimum off time in clocks (rounded up) and the off time needed to meet the duty ceiling.
- R3: Outside the off interval and while `dis_i` is low, `ramp_rel_o` is high.
- R4: Outside the off interval, a high `cmp_cross_i` sampled at a clock edge turns `gate_o` on after that edge. The gate stays on until the cycle ends unless R7 or R9 applies. The gate never rises without a high comparator sample at the previous edge.
- R5: With the comparator held high, the gate is on for exactly `PER_CYC - OFF_CYC - 1` clocks per cycle (379 of 400). This is no more than `DMAX_PCT` percent (95) of the period.
- R6: The filtered limit flag asserts only after `ilim_raw_i` has been sampled high at `FILT_CYC` consecutive edges (8 at defaults). A single low sample restarts the count, so a pulse lasting 7 samples has no effect on the gate.
- R7: When the filtered limit flag asserts, `gate_o` goes low in the same clock. It stays low until the next cycle's off interval, even if the raw flag drops.
- R8: Each off interval clears both the on latch and the limit latch. A comparator pulse that lies entirely inside the off interval therefore leaves the gate off for the whole cycle.
- R9: While `dis_i` is high, `gate_o` and `ramp_rel_o` are low and both latches are cleared. After `dis_i` falls, the gate needs a fresh comparator sample before it turns on.
- R10: While `rst_n` is low, `gate_o` and `ramp_rel_o` are low and `cyc_start_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_cross_i | input | 1 | Ramp has reached the averaged-current level |
| ilim_raw_i | input | 1 | Unfiltered peak-current-limit comparator output |
| dis_i | input | 1 | Protection disable; forces the gate off |
| gate_o | output | 1 | Switch gate drive, active high |
| ramp_rel_o | output | 1 | High while the ramp is allowed to rise |
| cyc_start_o | output | 1 | One-clock strobe at the start of each cycle |

## Verification
The case hardest to bring about from the ports is a limit flag pulse that sits exactly at the filter length. It must arrive in the middle of an on interval and then outlive its own raw input. Directed stimulus covers this case in two steps. It first places a 7-sample pulse well into the on interval and checks that the gate survives. It then applies an 8-sample pulse, releases the raw input, and checks that the gate stays off until the next off interval. A second hard case is a comparator pulse confined to the off window. For this, the stimulus waits for the cycle strobe and then pulses the comparator for three clocks. Long seeded random runs then toggle all three inputs at independent rates against a cycle-level reference model.

// File: rtl/pfc_pwm_pkg.sv
package pfc_pwm_pkg;

   // Convert a duration in nanoseconds to a clock count, rounding up.
   function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                             input longint unsigned hz);
      longint unsigned prod;
      prod = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
      return int'(prod[31:0]);
   endfunction

   function automatic int unsigned max_u(input int unsigned a,
                                         input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // Index of each latch in the latch vector.
   typedef enum int unsigned {
      LAT_ON  = 0,
      LAT_LIM = 1
   } lat_idx_e;

   localparam int unsigned LAT_N = 2;

endpackage

// File: rtl/pfc_pwm_timer.sv
module pfc_pwm_timer #(
   parameter int unsigned PER_CYC = 400,
   parameter int unsigned OFF_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   output logic cyc_start_o,
   output logic off_act_o
);
   localparam int unsigned CW = (PER_CYC > 1) ? $clog2(PER_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(PER_CYC - 1);
   localparam logic [CW-1:0] OFF_END = CW'(OFF_CYC);

   initial begin
      if (PER_CYC < 4) $fatal(1, "period too short");
      if (OFF_CYC == 0 || OFF_CYC >= PER_CYC - 1) $fatal(1, "off interval out of range");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign cyc_start_o = (cnt_q == '0);
   assign off_act_o   = (cnt_q < OFF_END);

   // R1
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start_o |=> !cyc_start_o);

   // R2
   strobe_in_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start_o |-> off_act_o);

endmodule

// File: rtl/pfc_pwm_filter.sv
module pfc_pwm_filter #(
   parameter int unsigned FILT_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic det_o
);
   generate
      if (FILT_CYC == 0) begin : g_bypass
         assign det_o = raw_i;
      end else begin : g_count
         localparam int unsigned FW = $clog2(FILT_CYC + 1);
         localparam logic [FW-1:0] FULL = FW'(FILT_CYC);
         logic [FW-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            run_q <= '0;
            else if (!raw_i)       run_q <= '0;
            else if (run_q != FULL) run_q <= run_q + 1'b1;
         end

         assign det_o = (run_q == FULL);

         // R6
         det_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(det_o) |-> $past(raw_i));
      end
   endgenerate

endmodule

// File: rtl/pfc_pwm_latch.sv
module pfc_pwm_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic set_i,
   output logic q_o
);
   // Clear wins over set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (clr_i) q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
   end
endmodule

// File: rtl/pfc_pwm_gate.sv
module pfc_pwm_gate
   import pfc_pwm_pkg::*;
#(
   parameter int unsigned CLK_HZ   = 26_000_000,
   parameter int unsigned SW_HZ    = 65_000,
   parameter int unsigned TOFF_NS  = 400,
   parameter int unsigned FILT_NS  = 300,
   parameter int unsigned DMAX_PCT = 95
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmp_cross_i,
   input  logic ilim_raw_i,
   input  logic dis_i,
   output logic gate_o,
   output logic ramp_rel_o,
   output logic cyc_start_o
);
   localparam int unsigned PER_CYC   = CLK_HZ / SW_HZ;
   localparam int unsigned TOFF_MIN  = ns_to_cyc(TOFF_NS, CLK_HZ);
   localparam int unsigned TOFF_DUTY = (PER_CYC * (100 - DMAX_PCT) + 99) / 100;
   localparam int unsigned OFF_CYC   = max_u(TOFF_MIN, TOFF_DUTY);
   localparam int unsigned FILT_CYC  = ns_to_cyc(FILT_NS, CLK_HZ);

   initial begin
      if (SW_HZ == 0 || SW_HZ > CLK_HZ / 4) $fatal(1, "switching rate too high");
      if (DMAX_PCT == 0 || DMAX_PCT > 99) $fatal(1, "duty ceiling out of range");
      if ((PER_CYC - OFF_CYC - 1) * 100 > PER_CYC * DMAX_PCT) $fatal(1, "duty ceiling not met");
   end

   logic             cyc_start;
   logic             off_act;
   logic             lim_det;
   logic             clr;
   logic [LAT_N-1:0] set_v;
   logic [LAT_N-1:0] q_v;

   pfc_pwm_timer #(.PER_CYC(PER_CYC), .OFF_CYC(OFF_CYC)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .cyc_start_o (cyc_start),
      .off_act_o   (off_act)
   );

   pfc_pwm_filter #(.FILT_CYC(FILT_CYC)) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (ilim_raw_i),
      .det_o (lim_det)
   );

   assign clr            = off_act | dis_i;
   assign set_v[LAT_ON]  = cmp_cross_i;
   assign set_v[LAT_LIM] = lim_det;

   for (genvar k = 0; k < LAT_N; k++) begin : g_lat
      pfc_pwm_latch u_lat (
         .clk   (clk),
         .rst_n (rst_n),
         .clr_i (clr),
         .set_i (set_v[k]),
         .q_o   (q_v[k])
      );
   end

   assign gate_o      = q_v[LAT_ON] & ~q_v[LAT_LIM] & ~lim_det & ~clr;
   assign ramp_rel_o  = ~clr;
   assign cyc_start_o = cyc_start;

   // R2
   off_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_act |-> (!gate_o && !ramp_rel_o));

   // R9
   dis_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_i |-> (!gate_o && !ramp_rel_o));

   // R7
   lim_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_det || q_v[LAT_LIM]) |-> !gate_o);

   // R4
   gate_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o) |-> $past(cmp_cross_i));

   // R8
   new_cycle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |=> (!q_v[LAT_ON] && !q_v[LAT_LIM]));

endmodule

// File: tb/sim_pfc_pwm_gate.sv
module sim_pfc_pwm_gate;
   localparam int CLK_PER = 10;
   localparam int PER     = 400;
   localparam int OFF     = 20;
   localparam int FLT     = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmp = 1'b0;
   logic ilim = 1'b0;
   logic dis = 1'b0;
   logic gate, ramp, cyc;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   pfc_pwm_gate u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmp_cross_i (cmp),
      .ilim_raw_i  (ilim),
      .dis_i       (dis),
      .gate_o      (gate),
      .ramp_rel_o  (ramp),
      .cyc_start_o (cyc)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Cycle-level reference built from the requirements.
   int m_cnt;
   bit m_on, m_lim;
   int m_fc;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 0; m_on <= 1'b0; m_lim <= 1'b0; m_fc <= 0;
      end else begin
         m_cnt <= (m_cnt == PER - 1) ? 0 : m_cnt + 1;
         if ((m_cnt < OFF) || dis) begin
            m_on <= 1'b0; m_lim <= 1'b0;
         end else begin
            if (cmp) m_on <= 1'b1;
            if (m_fc == FLT) m_lim <= 1'b1;
         end
         m_fc <= ilim ? ((m_fc < FLT) ? m_fc + 1 : m_fc) : 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit e_off, e_gate, e_ramp, e_cyc;
         string gt, rt;
         e_off  = (m_cnt < OFF);
         e_gate = m_on && !m_lim && (m_fc != FLT) && !e_off && !dis;
         e_ramp = !e_off && !dis;
         e_cyc  = (m_cnt == 0);
         gt = e_off ? "R2" : dis ? "R9" : (m_lim || m_fc == FLT) ? "R7" : "R4";
         rt = e_off ? "R2" : dis ? "R9" : "R3";
         chk(gate == e_gate, gt, "gate", int'(gate), int'(e_gate));
         chk(ramp == e_ramp, rt, "ramp", int'(ramp), int'(e_ramp));
         chk(cyc == e_cyc, "R1", "strobe", int'(cyc), int'(e_cyc));
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      #(CLK_PER * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=1 expected=0");
         done = 1'b1;
         summary();
         $finish;
      end
   end

   initial begin
      int hi, rr, extra;
      void'($urandom(32'd20250611));
      // R10 reset state
      repeat (3) @(negedge clk);
      chk(gate == 1'b0, "R10", "gate in reset", int'(gate), 0);
      chk(ramp == 1'b0, "R10", "ramp in reset", int'(ramp), 0);
      chk(cyc == 1'b1, "R10", "strobe in reset", int'(cyc), 1);
      @(posedge clk); #1 rst_n = 1'b1;

      // R5 / R3 / R1: comparator held high for a full cycle
      cmp = 1'b1;
      do @(negedge clk); while (!cyc);
      hi = 0; rr = 0; extra = 0;
      for (int i = 0; i < PER; i++) begin
         if (i > 0) @(negedge clk);
         hi += int'(gate);
         rr += int'(ramp);
         if (i > 0 && cyc) extra++;
      end
      @(negedge clk);
      chk(cyc == 1'b1 && extra == 0, "R1", "strobe spacing", extra, 0);
      chk(hi == PER - OFF - 1, "R5", "gate clocks per cycle", hi, PER - OFF - 1);
      chk(hi * 100 <= PER * 95, "R5", "duty ceiling", hi, PER * 95 / 100);
      chk(rr == PER - OFF, "R3", "ramp clocks per cycle", rr, PER - OFF);

      // R6: 7-sample limit pulse is rejected
      repeat (100) @(negedge clk);
      @(posedge clk); #1 ilim = 1'b1;
      repeat (FLT - 1) @(posedge clk);
      #1 ilim = 1'b0;
      @(negedge clk);
      chk(gate == 1'b1, "R6", "gate after short pulse", int'(gate), 1);

      // R7: 8-sample pulse cuts the gate and it stays off
      @(posedge clk); #1 ilim = 1'b1;
      repeat (FLT) @(posedge clk);
      #1 ilim = 1'b0;
      @(negedge clk);
      chk(gate == 1'b0, "R7", "gate at filtered limit", int'(gate), 0);
      repeat (5) @(negedge clk);
      chk(gate == 1'b0, "R7", "gate after raw flag drop", int'(gate), 0);

      // R8: comparator pulse inside the off window only
      @(posedge clk); #1 cmp = 1'b0;
      do @(negedge clk); while (!cyc);
      @(posedge clk); #1 cmp = 1'b1;
      repeat (3) @(posedge clk);
      #1 cmp = 1'b0;
      repeat (50) @(negedge clk);
      chk(gate == 1'b0, "R8", "gate after off-window pulse", int'(gate), 0);
      chk(ramp == 1'b1, "R3", "ramp released", int'(ramp), 1);

      // R9: disable mid on-time, latches cleared
      @(posedge clk); #1 cmp = 1'b1;
      repeat (10) @(negedge clk);
      chk(gate == 1'b1, "R4", "gate on after comparator", int'(gate), 1);
      @(posedge clk); #1 dis = 1'b1;
      @(negedge clk);
      chk(gate == 1'b0 && ramp == 1'b0, "R9", "outputs under disable",
          int'(gate) + int'(ramp), 0);
      @(posedge clk); #1 dis = 1'b0;
      @(negedge clk);
      chk(gate == 1'b0, "R9", "gate right after disable release", int'(gate), 0);
      repeat (2) @(negedge clk);

      // Seeded random phase, checked every clock by the reference
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk); #1;
         if ($urandom_range(39) == 0) cmp = ~cmp;
         if ($urandom_range(29) == 0) ilim = ~ilim;
         if ($urandom_range(499) == 0) dis = ~dis;
      end
      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule